// File: doc/BRIEF.md
# Keyed Watchdog Timer with Staged NMI and Reset

This block is a hardware watchdog for a processor subsystem. A free-running prescaler divides the fast system clock into a slow tick. With the default divide of 131072, a 100 MHz clock gives about 763 Hz. An 8-bit counter steps down once per tick from a start value that software programs.

When the counter steps from 2 to 1, the block emits a one-cycle non-maskable interrupt request. This gives software a last chance to react. When a tick arrives with the count at 1 or 0, the block raises a system reset request for a fixed number of cycles.

Software controls the watchdog through one control write. The write carries an 8-bit count, a one-bit command (1 = run/reload, 0 = halt) and a 7-bit key. A write takes effect only if its key is the bitwise inverse of the last accepted key, so a stray write cannot kick or disable the watchdog.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `nmi_o` and `sys_rst_o` are 0, `cnt_o` is 0 and the watchdog is halted. The stored key is `KEY_INIT` (default 7'h2A), so the first valid key is 7'h55.
- R2: A write (`wr_en` = 1) is accepted only when `wr_key` equals the bitwise inverse of the last accepted key. An accepted key becomes the new stored key. Any other write changes nothing, which is visible on `cnt_o` and on the event outputs.
- R3: An accepted write with `wr_cmd` = 1 loads `wr_cnt` into the counter and sets the watchdog running from the next cycle. It also restarts the prescaler from zero. The same write while running acts as a kick.
- R4: An accepted write with `wr_cmd` = 0 halts the watchdog. `cnt_o` then holds its value, and neither event fires while halted.
- R5: While running, the counter steps down by one every `PRESCALE_DIV` system cycles, counted from the edge that accepted the start.
- R6: When a step takes the count from 2 to 1, `nmi_o` is high for exactly one cycle. This is the cycle in which `cnt_o` first shows 1.
- R7: When a tick arrives with the count at 1 or 0, the counter goes to 0 and the watchdog halts. `sys_rst_o` is then high for exactly `RST_CYCLES` cycles, starting with the cycle in which `cnt_o` first shows 0.
- R8: A halt write with a wrong key does not halt the watchdog, and counting continues.
- R9: An accepted write in the same cycle as a tick takes priority, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_cnt | input | 8 | Start value carried by the write |
| wr_cmd | input | 1 | 1 = run/reload, 0 = halt |
| wr_key | input | 7 | Key; must be the inverse of the last accepted key |
| cnt_o | output | 8 | Current watchdog count |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request |
| sys_rst_o | output | 1 | System reset request, held `RST_CYCLES` cycles |

## Verification
The bench aims at the key chain. It sends a key that is wrong from reset, a halt carrying a stale key, and alternating valid keys. A design that compared against a fixed key, or updated the stored key on rejected writes, would start or halt when it should not.

The bench also places a kick on the exact cycle of a prescaler tick. A design that let the tick win would show a count one lower than loaded.

It starts from counts of 2, 1 and 0. A design that fired its NMI on level rather than on the 2-to-1 step would pulse repeatedly or at the wrong count. A design that failed to expire from a loaded 0 would wrap to 255.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int WD_CNT_W = 8;
    localparam int WD_KEY_W = 7;

    typedef enum logic {
        WD_HALT = 1'b0,
        WD_RUN  = 1'b1
    } wd_cmd_e;

    typedef struct packed {
        logic [WD_CNT_W-1:0] count;
        wd_cmd_e             cmd;
        logic [WD_KEY_W-1:0] key;
    } wd_write_t;

    function automatic logic key_matches(input logic [WD_KEY_W-1:0] stored,
                                         input logic [WD_KEY_W-1:0] cand);
        return cand == ~stored;
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int DIV = 131072
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] phase_q;

    assign tick = en && (phase_q == PW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_keycheck.sv
module wdg_keycheck
    import wdg_pkg::*;
#(
    parameter logic [WD_KEY_W-1:0] KEY_INIT = 7'h2A
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WD_KEY_W-1:0] wr_key,
    output logic                accept,
    output logic [WD_KEY_W-1:0] last_key
);
    assign accept = wr_en && key_matches(last_key, wr_key);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_key <= KEY_INIT;
        end else if (accept) begin
            last_key <= wr_key;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  wd_write_t           wr,
    input  logic                tick,
    output logic [WD_CNT_W-1:0] cnt,
    output logic                running,
    output logic                nmi,
    output logic                sys_rst
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic          do_load, do_halt, do_step, expire;
    logic [RW-1:0] rst_left_q;

    assign do_load = accept && (wr.cmd == WD_RUN);
    assign do_halt = accept && (wr.cmd == WD_HALT);
    assign do_step = !accept && running && tick;
    assign expire  = do_step && (cnt <= WD_CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            running    <= 1'b0;
            nmi        <= 1'b0;
            rst_left_q <= '0;
        end else begin
            if (do_load) begin
                cnt     <= wr.count;
                running <= 1'b1;
            end else if (do_halt) begin
                running <= 1'b0;
            end else if (expire) begin
                cnt     <= '0;
                running <= 1'b0;
            end else if (do_step) begin
                cnt <= cnt - 1'b1;
            end
            nmi <= do_step && (cnt == WD_CNT_W'(2));
            if (expire) begin
                rst_left_q <= RW'(RST_CYCLES);
            end else if (rst_left_q != '0) begin
                rst_left_q <= rst_left_q - 1'b1;
            end
        end
    end

    assign sys_rst = (rst_left_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int                  PRESCALE_DIV = 131072,
    parameter int                  RST_CYCLES   = 16,
    parameter logic [WD_KEY_W-1:0] KEY_INIT     = 7'h2A
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WD_CNT_W-1:0] wr_cnt,
    input  logic                wr_cmd,
    input  logic [WD_KEY_W-1:0] wr_key,
    output logic [WD_CNT_W-1:0] cnt_o,
    output logic                nmi_o,
    output logic                sys_rst_o
);
    wd_write_t           wr_word;
    logic                key_accept;
    logic [WD_KEY_W-1:0] stored_key;
    logic                wd_running;
    logic                slow_tick;
    logic                pre_clr;

    assign wr_word.count = wr_cnt;
    assign wr_word.cmd   = wd_cmd_e'(wr_cmd);
    assign wr_word.key   = wr_key;

    assign pre_clr = !wd_running || (key_accept && wr_word.cmd == WD_RUN);

    wdg_keycheck #(.KEY_INIT(KEY_INIT)) u_key (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_key(wr_key),
        .accept(key_accept), .last_key(stored_key)
    );

    wdg_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk(clk), .rst(rst), .clr(pre_clr), .en(wd_running), .tick(slow_tick)
    );

    wdg_counter #(.RST_CYCLES(RST_CYCLES)) u_cnt (
        .clk(clk), .rst(rst), .accept(key_accept), .wr(wr_word),
        .tick(slow_tick), .cnt(cnt_o), .running(wd_running),
        .nmi(nmi_o), .sys_rst(sys_rst_o)
    );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
    input logic       clk,
    input logic       rst,
    input logic       accept,
    input logic [7:0] cnt_o,
    input logic       nmi_o,
    input logic       sys_rst_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R6
    nmi_single_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_o |=> !nmi_o);

    // R6
    nmi_at_one_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_o |-> cnt_o == 8'd1);

    // R7
    rst_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(sys_rst_o)) |-> cnt_o == 8'd0);

    // R3
    load_only_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && cnt_o > $past(cnt_o)) |-> $past(accept));

    // R5
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(accept) && cnt_o != $past(cnt_o) && cnt_o != 8'd0)
            |-> cnt_o == 8'($past(cnt_o) - 8'd1));
endmodule

bind keyed_watchdog wdg_checker u_chk (
    .clk(clk), .rst(rst), .accept(key_accept),
    .cnt_o(cnt_o), .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int DIV  = 4;
    localparam int RSTC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_cnt = '0;
    logic       wr_cmd = 1'b0;
    logic [6:0] wr_key = '0;
    logic [7:0] cnt_o;
    logic       nmi_o, sys_rst_o;

    always #4 clk = ~clk;

    keyed_watchdog #(.PRESCALE_DIV(DIV), .RST_CYCLES(RSTC), .KEY_INIT(7'h2A)) u_keyed_watchdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cnt(wr_cnt), .wr_cmd(wr_cmd),
        .wr_key(wr_key), .cnt_o(cnt_o), .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [6:0] m_key;
    int m_cnt, m_pc, m_rstc;
    bit m_run, m_nmi;

    always @(posedge clk) begin
        bit acc, tk;
        cycles++;
        if (rst) begin
            m_key = 7'h2A; m_cnt = 0; m_pc = 0; m_rstc = 0; m_run = 0; m_nmi = 0;
        end else begin
            acc = wr_en && (wr_key == ~m_key);
            tk  = m_run && (m_pc == DIV - 1);
            m_nmi = 0;
            if (m_rstc > 0) m_rstc--;
            if (acc) begin
                m_key = wr_key;
                m_pc  = 0;
                if (wr_cmd) begin m_cnt = wr_cnt; m_run = 1; end
                else m_run = 0;
            end else if (m_run) begin
                if (tk) begin
                    m_pc = 0;
                    if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; m_rstc = RSTC; end
                    else begin m_cnt--; if (m_cnt == 1) m_nmi = 1; end
                end else m_pc++;
            end else m_pc = 0;
        end
    end

    task automatic check(string req, string what, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at cycle %0d", req, what, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "cnt_o", int'(cnt_o), m_cnt);
            check(cur_req, "nmi_o", int'(nmi_o), int'(m_nmi));
            check(cur_req, "sys_rst_o", int'(sys_rst_o), int'(m_rstc > 0));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] c, logic cmd, logic [6:0] k);
        @(negedge clk);
        wr_en = 1'b1; wr_cnt = c; wr_cmd = cmd; wr_key = k;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        idle(3);
        // R1 reset state
        check("R1", "cnt_o in reset", int'(cnt_o), 0);
        check("R1", "nmi_o in reset", int'(nmi_o), 0);
        check("R1", "sys_rst_o in reset", int'(sys_rst_o), 0);
        rst = 1'b0;
        idle(4);
        cur_req = "R2";                 // wrong first key ignored
        wr(8'd5, 1'b1, 7'h11);
        idle(10);
        cur_req = "R6";                 // start 3: NMI then reset (R5, R7)
        wr(8'd3, 1'b1, 7'h55);
        idle(20);
        cur_req = "R3";                 // start then kicks
        wr(8'd10, 1'b1, 7'h2A);
        idle(6);
        wr(8'd10, 1'b1, 7'h55);
        idle(7);
        wr(8'd9, 1'b1, 7'h2A);
        idle(5);
        cur_req = "R8";                 // halt with stale key
        wr(8'd0, 1'b0, 7'h2A);
        idle(9);
        cur_req = "R4";                 // valid halt holds count
        wr(8'd0, 1'b0, 7'h55);
        idle(20);
        cur_req = "R9";                 // kick on the tick edge
        wr(8'd4, 1'b1, 7'h2A);
        idle(2);
        wr(8'd4, 1'b1, 7'h55);
        idle(6);
        cur_req = "R7";                 // loads of 2, 1 and 0
        wr(8'd2, 1'b1, 7'h2A);
        idle(14);
        wr(8'd1, 1'b1, 7'h55);
        idle(10);
        wr(8'd0, 1'b1, 7'h2A);
        idle(10);
        cur_req = "R2";                 // rejected write during halt
        wr(8'd7, 1'b1, 7'h2A);
        idle(6);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog: bench hung, got %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule